// File: doc/BRIEF.md
# Converter Power and Calibration Sequencer

This block sequences the power state of a data converter. It derives the converter clock enable from the bus clock. It enforces a settling time after power-up. It runs the reset-calibration step and the calibration step, and it turns a repeated power-on write into a conversion start. Software drives one write strobe that carries three command bits: power, reset calibration, and calibrate. It reads back status bits that the hardware raises and clears without further software action.

A prescaler divides the bus clock by 2, 4, 6 or 8 to make a one-cycle converter tick. Every timing rule that belongs to the converter counts in these ticks: the off-time history, the reset-calibration length and the calibration length. The stabilization delay counts in bus clocks. The analog calibration itself is replaced by a stub that finishes after a fixed number of ticks.

A calibrate request is accepted only if the converter spent enough ticks switched off before its most recent power-up. Otherwise the request raises an error flag and leaves the calibrate status clear.

Top module: `pwrcal_ctrl`

## Requirements
- R1: While `cken` is 1, `conv_tick` pulses for one bus cycle once every 2*(`presc_sel`+1) bus cycles, so codes 0, 1, 2 and 3 give division by 2, 4, 6 and 8.
- R2: While `cken` is 0, `conv_tick` stays 0, and a running calibration does not advance: `cal_busy` stays 1.
- R3: A write with the power bit set while `pwr_on` is 0 sets `pwr_on` after that edge and produces no `conv_start`. `ready` rises exactly STAB_CLKS bus cycles after the write edge.
- R4: A write with the power bit set, and the reset-calibration and calibrate bits clear, made while `ready` is 1, makes `conv_start` 1 for the single cycle after the write edge.
- R5: A conversion write made while the converter is stabilizing, calibrating or resetting calibration has no effect: `conv_start` stays 0.
- R6: A calibrate write made while `ready` is 1 and with an off history of at least MIN_OFF_TICKS ticks sets `cal_busy` and clears `cal_err`. `cal_busy` then stays 1 for exactly CAL_TICKS converter ticks, after which it clears and `cal_valid` is 1.
- R7: A calibrate write made while `ready` is 1 but with an off history below MIN_OFF_TICKS ticks sets `cal_err` and leaves `cal_busy` and `cal_valid` unchanged. The off history is the number of ticks seen between the latest power-off (or reset) and the power-on write edge, including the tick in the cycle of that write.
- R8: A reset-calibration write made while `ready` is 1 clears `cal_valid` at once and holds `rst_cal_busy` at 1 for exactly RSTCAL_TICKS ticks. If the calibrate bit is set in the same write, that bit is ignored.
- R9: A write with the power bit clear sets `pwr_on`, `ready`, `cal_busy`, `rst_cal_busy` and `cal_err` to 0 after that edge, aborting any step in progress, and restarts the off history from zero.
- R10: After reset, `pwr_on`, `ready`, `cal_busy`, `rst_cal_busy`, `cal_err`, `cal_valid`, `conv_start` and `conv_tick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cken | input | 1 | Converter clock enable |
| presc_sel | input | 2 | Prescaler code, divide by 2*(code+1) |
| wr_en | input | 1 | Command write strobe |
| wr_pwr | input | 1 | Power bit of the write |
| wr_rstcal | input | 1 | Reset-calibration bit of the write |
| wr_cal | input | 1 | Calibrate bit of the write |
| conv_tick | output | 1 | One-cycle converter clock enable |
| pwr_on | output | 1 | Converter powered |
| ready | output | 1 | Powered, settled and idle |
| rst_cal_busy | output | 1 | Reset-calibration in progress, self-clearing |
| cal_busy | output | 1 | Calibration in progress, self-clearing |
| cal_err | output | 1 | Last calibrate request lacked off history |
| cal_valid | output | 1 | Calibration result stored |
| conv_start | output | 1 | One-cycle conversion start |

## Verification
The bench counts the ticks between each power-off and the following power-on. It picks random waits so that the count lands on both sides of the two-tick limit, then checks whether the calibrate request is accepted or flagged. A design that sampled the history one tick late, or counted ticks while powered, would accept or refuse the wrong requests. The bench measures the settling delay to the exact cycle and counts the ticks that each self-clearing bit stays high. An off-by-one counter shows up as a wrong count. It also sends conversion writes during settling and during calibration, and powers off in the middle of a calibration. A design that started conversions too early, or left a busy bit set after power-off, is caught.

// File: rtl/pwrcal_pkg.sv
`timescale 1ns/1ps
package pwrcal_pkg;
   localparam int unsigned PRESC_CODE_W = 2;
   localparam int unsigned MAX_DIV      = 2 * (1 << PRESC_CODE_W);

   function automatic int unsigned ctr_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/pwrcal_presc.sv
`timescale 1ns/1ps
module pwrcal_presc
   import pwrcal_pkg::*;
#(
   parameter int unsigned CODE_W = PRESC_CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cken,
   input  logic [CODE_W-1:0] sel,
   output logic              tick
);
   localparam int unsigned DW = CODE_W + 1;

   logic [DW-1:0] cnt;
   logic [DW-1:0] lim;

   // division factor 2*(sel+1) means terminal count 2*sel+1
   assign lim = {sel, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n || !cken) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R1
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R2
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cken |=> !tick);
endmodule

// File: rtl/pwrcal_timer.sv
`timescale 1ns/1ps
module pwrcal_timer
   import pwrcal_pkg::*;
#(
   parameter int unsigned TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic tick,
   output logic busy,
   output logic done
);
   localparam int unsigned W = ctr_width(TICKS);

   if (TICKS < 1) begin : g_bad_ticks
      $error("pwrcal_timer: TICKS must be at least 1");
   end

   logic [W-1:0] cnt;

   assign busy = (cnt != '0);
   assign done = busy && tick && (cnt == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || abort)      cnt <= '0;
      else if (start)           cnt <= W'(TICKS);
      else if (busy && tick)    cnt <= cnt - 1'b1;
   end

   // R6
   timer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !abort) |=> busy);
   // R9
   timer_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);
   // R2
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !abort && !start) |=> busy);
endmodule

// File: rtl/pwrcal_fsm.sv
`timescale 1ns/1ps
module pwrcal_fsm
   import pwrcal_pkg::*;
#(
   parameter int unsigned STAB_CLKS     = 20,
   parameter int unsigned MIN_OFF_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_pwr,
   input  logic wr_rstcal,
   input  logic wr_cal,
   input  logic tick,
   input  logic cal_busy,
   input  logic cal_done,
   input  logic rst_busy,
   input  logic rst_done,
   output logic cal_go,
   output logic rst_go,
   output logic abort,
   output logic pwr_q,
   output logic ready,
   output logic err_q,
   output logic valid_q,
   output logic conv_q
);
   localparam int unsigned OW = ctr_width(MIN_OFF_TICKS);

   if (MIN_OFF_TICKS < 1) begin : g_bad_off
      $error("pwrcal_fsm: MIN_OFF_TICKS must be at least 1");
   end

   logic [OW-1:0] off_cnt, off_nxt;
   logic          hist_ok;
   logic          stab_done;
   logic          pon_req, act, cal_try, conv_go;

   assign pon_req = wr_en && wr_pwr && !pwr_q;
   assign abort   = wr_en && !wr_pwr;
   assign act     = wr_en && wr_pwr && ready;
   assign rst_go  = act && wr_rstcal;
   assign cal_try = act && !wr_rstcal && wr_cal;
   assign cal_go  = cal_try && hist_ok;
   assign conv_go = act && !wr_rstcal && !wr_cal;
   assign ready   = pwr_q && stab_done && !cal_busy && !rst_busy;

   assign off_nxt = (off_cnt == OW'(MIN_OFF_TICKS)) ? off_cnt : off_cnt + OW'(tick);

   if (STAB_CLKS == 0) begin : g_no_stab
      assign stab_done = 1'b1;
   end else begin : g_stab
      localparam int unsigned SW = ctr_width(STAB_CLKS);
      logic [SW-1:0] stab_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || abort)        stab_cnt <= '0;
         else if (pon_req)           stab_cnt <= SW'(STAB_CLKS);
         else if (stab_cnt != '0)    stab_cnt <= stab_cnt - 1'b1;
      end
      assign stab_done = (stab_cnt == '0);

      // R3
      stab_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pwr_q) |-> !ready);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_q   <= 1'b0;
         off_cnt <= '0;
         hist_ok <= 1'b0;
         err_q   <= 1'b0;
         valid_q <= 1'b0;
         conv_q  <= 1'b0;
      end else begin
         conv_q <= conv_go;
         if (abort) begin
            pwr_q   <= 1'b0;
            off_cnt <= '0;
            err_q   <= 1'b0;
         end else begin
            if (pon_req) begin
               pwr_q   <= 1'b1;
               hist_ok <= (off_nxt >= OW'(MIN_OFF_TICKS));
            end
            if (!pwr_q) off_cnt <= off_nxt;
            if (cal_try) err_q <= !hist_ok;
         end
         if (rst_go || rst_done) valid_q <= 1'b0;
         else if (cal_done)      valid_q <= 1'b1;
      end
   end

   // R4
   conv_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_q |-> pwr_q);
   // R7
   cal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_busy) |-> !err_q);
   // R9
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_q |-> (!cal_busy && !rst_busy && !ready));
   // R6
   cal_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cal_busy) && pwr_q) |-> valid_q);
   // R8
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_busy |-> !valid_q);
endmodule

// File: rtl/pwrcal_ctrl.sv
`timescale 1ns/1ps
module pwrcal_ctrl
   import pwrcal_pkg::*;
#(
   parameter int unsigned STAB_CLKS     = 20,
   parameter int unsigned MIN_OFF_TICKS = 2,
   parameter int unsigned CAL_TICKS     = 6,
   parameter int unsigned RSTCAL_TICKS  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cken,
   input  logic [PRESC_CODE_W-1:0] presc_sel,
   input  logic                    wr_en,
   input  logic                    wr_pwr,
   input  logic                    wr_rstcal,
   input  logic                    wr_cal,
   output logic                    conv_tick,
   output logic                    pwr_on,
   output logic                    ready,
   output logic                    rst_cal_busy,
   output logic                    cal_busy,
   output logic                    cal_err,
   output logic                    cal_valid,
   output logic                    conv_start
);
   logic cal_go, rst_go, abort, cal_done, rst_done;

   pwrcal_presc #(.CODE_W(PRESC_CODE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .cken(cken), .sel(presc_sel), .tick(conv_tick)
   );

   // stub calibration engine with fixed latency in ticks
   pwrcal_timer #(.TICKS(CAL_TICKS)) u_cal (
      .clk(clk), .rst_n(rst_n), .start(cal_go), .abort(abort),
      .tick(conv_tick), .busy(cal_busy), .done(cal_done)
   );

   pwrcal_timer #(.TICKS(RSTCAL_TICKS)) u_rstcal (
      .clk(clk), .rst_n(rst_n), .start(rst_go), .abort(abort),
      .tick(conv_tick), .busy(rst_cal_busy), .done(rst_done)
   );

   pwrcal_fsm #(.STAB_CLKS(STAB_CLKS), .MIN_OFF_TICKS(MIN_OFF_TICKS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pwr(wr_pwr),
      .wr_rstcal(wr_rstcal), .wr_cal(wr_cal), .tick(conv_tick),
      .cal_busy(cal_busy), .cal_done(cal_done), .rst_busy(rst_cal_busy),
      .rst_done(rst_done), .cal_go(cal_go), .rst_go(rst_go), .abort(abort),
      .pwr_q(pwr_on), .ready(ready), .err_q(cal_err), .valid_q(cal_valid),
      .conv_q(conv_start)
   );

   // R8
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_busy && rst_cal_busy));
endmodule

// File: tb/tb_pwrcal_ctrl.sv
`timescale 1ns/1ps
module tb_pwrcal_ctrl;
   localparam int STAB = 20;
   localparam int MINOFF = 2;
   localparam int CALT = 6;
   localparam int RSTT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cken = 1'b1;
   logic [1:0] presc_sel = 2'd3;
   logic wr_en = 1'b0, wr_pwr = 1'b0, wr_rstcal = 1'b0, wr_cal = 1'b0;
   logic conv_tick, pwr_on, ready, rst_cal_busy, cal_busy, cal_err, cal_valid, conv_start;

   int n_run = 0;
   int n_fail = 0;
   int offt;

   always #10 clk = ~clk;

   pwrcal_ctrl #(.STAB_CLKS(STAB), .MIN_OFF_TICKS(MINOFF), .CAL_TICKS(CALT),
                 .RSTCAL_TICKS(RSTT)) dut (
      .clk(clk), .rst_n(rst_n), .cken(cken), .presc_sel(presc_sel),
      .wr_en(wr_en), .wr_pwr(wr_pwr), .wr_rstcal(wr_rstcal), .wr_cal(wr_cal),
      .conv_tick(conv_tick), .pwr_on(pwr_on), .ready(ready),
      .rst_cal_busy(rst_cal_busy), .cal_busy(cal_busy), .cal_err(cal_err),
      .cal_valid(cal_valid), .conv_start(conv_start)
   );

   function automatic int exp_div(input int sel);
      return 2 * (sel + 1);
   endfunction

   function automatic bit exp_err(input int ticks_off);
      return ticks_off < MINOFF;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // returns at the negedge right after the write edge
   task automatic wr(input bit p, input bit r, input bit c);
      @(negedge clk);
      if (!pwr_on) offt += int'(conv_tick);
      wr_en = 1'b1; wr_pwr = p; wr_rstcal = r; wr_cal = c;
      @(negedge clk);
      wr_en = 1'b0; wr_pwr = 1'b0; wr_rstcal = 1'b0; wr_cal = 1'b0;
   endtask

   task automatic power_off();
      wr(1'b0, 1'b0, 1'b0);
      offt = int'(conv_tick);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!pwr_on) offt += int'(conv_tick);
      end
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
   endtask

   // counts ticks while busy sig stays high; which=0 cal, 1 rstcal
   task automatic count_busy(input int which, output int nt);
      nt = 0;
      for (int i = 0; i < 400; i++) begin
         if (which == 0 ? !cal_busy : !rst_cal_busy) break;
         nt += int'(conv_tick);
         @(negedge clk);
      end
   endtask

   task automatic measure_period(input int sel, output int per);
      presc_sel = sel[1:0];
      per = 0;
      for (int i = 0; i < 40 && !conv_tick; i++) @(negedge clk);
      for (int i = 0; i < 40 && !conv_tick; i++) @(negedge clk);
      @(negedge clk);
      per = 1;
      for (int i = 0; i < 40 && !conv_tick; i++) begin
         @(negedge clk);
         per++;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int nt, per, w;
      bit e;
      void'($urandom(32'h5eed1234));
      offt = 0;
      repeat (4) @(negedge clk);
      // R10 reset state
      chk("R10 pwr_on", int'(pwr_on), 0);
      chk("R10 ready", int'(ready), 0);
      chk("R10 busy", int'(cal_busy | rst_cal_busy), 0);
      chk("R10 err/valid", int'(cal_err | cal_valid), 0);
      chk("R10 conv/tick", int'(conv_start | conv_tick), 0);
      rst_n = 1'b1;
      offt = 0;

      // R3 power up right after reset, exact settle time
      wr(1'b1, 1'b0, 1'b0);
      chk("R3 pwr_on", int'(pwr_on), 1);
      chk("R3 no conv", int'(conv_start), 0);
      idle(STAB - 1);
      chk("R3 ready early", int'(ready), 0);
      @(negedge clk);
      chk("R3 ready on time", int'(ready), 1);

      // R7 no off history after reset
      wr(1'b1, 1'b0, 1'b1);
      chk("R7 err", int'(cal_err), 1);
      chk("R7 busy", int'(cal_busy), 0);
      chk("R7 valid", int'(cal_valid), 0);

      // R9 power-off clears err
      power_off();
      chk("R9 err cleared", int'(cal_err), 0);
      chk("R9 pwr_on", int'(pwr_on), 0);

      // R1 prescaler periods
      for (int s = 0; s < 4; s++) begin
         measure_period(s, per);
         chk($sformatf("R1 div sel %0d", s), per, exp_div(s));
      end

      // R5 conversion during stabilization; R6 calibration
      presc_sel = 2'd1;
      offt = 0;
      idle(30);
      wr(1'b1, 1'b0, 1'b0);
      wr(1'b1, 1'b0, 1'b0);
      chk("R5 conv during settle", int'(conv_start), 0);
      wait_ready();
      wr(1'b1, 1'b0, 1'b1);
      chk("R6 cal_busy set", int'(cal_busy), 1);
      chk("R6 err clear", int'(cal_err), 0);
      wr(1'b1, 1'b0, 1'b0);
      chk("R5 conv during cal", int'(conv_start), 0);
      // R2 stall while cken low
      cken = 1'b0;
      idle(40);
      chk("R2 no tick", int'(conv_tick), 0);
      chk("R2 cal held", int'(cal_busy), 1);
      cken = 1'b1;
      count_busy(0, nt);
      // one tick was spent before the stall plus the rest after
      chk("R6 cal_valid", int'(cal_valid), 1);
      chk("R6 ready after cal", int'(ready), 1);

      // R6 exact tick count of calibration
      wr(1'b1, 1'b0, 1'b1);
      count_busy(0, nt);
      chk("R6 cal ticks", nt, CALT);

      // R4 conversion start
      wr(1'b1, 1'b0, 1'b0);
      chk("R4 conv_start", int'(conv_start), 1);
      @(negedge clk);
      chk("R4 single pulse", int'(conv_start), 0);

      // R8 reset calibration wins over calibrate bit
      wr(1'b1, 1'b1, 1'b1);
      chk("R8 valid cleared", int'(cal_valid), 0);
      chk("R8 rst busy", int'(rst_cal_busy), 1);
      chk("R8 cal ignored", int'(cal_busy), 0);
      count_busy(1, nt);
      chk("R8 rst ticks", nt, RSTT);
      chk("R8 ready after", int'(ready), 1);

      // R9 abort mid-calibration
      wr(1'b1, 1'b0, 1'b1);
      idle(3);
      power_off();
      chk("R9 cal aborted", int'(cal_busy), 0);
      chk("R9 ready low", int'(ready), 0);
      chk("R9 pwr off", int'(pwr_on), 0);

      // random power cycles around the history limit
      for (int it = 0; it < 40; it++) begin
         presc_sel = 2'($urandom % 4);
         power_off();
         w = $urandom % 24;
         idle(w);
         wr(1'b1, 1'b0, 1'b0);
         wait_ready();
         e = exp_err(offt);
         wr(1'b1, 1'b0, 1'b1);
         chk("R7 random err", int'(cal_err), int'(e));
         chk("R6 random busy", int'(cal_busy), int'(!e));
         if (!e) begin
            count_busy(0, nt);
            chk("R6 random ticks", nt, CALT);
         end
         wr(1'b1, 1'b0, 1'b0);
         chk("R4 random conv", int'(conv_start), 1);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule